// File: doc/BRIEF.md
# Ping-Pong Playback Address Engine

The engine produces read addresses for audio playback from two memory regions used in alternation. Software programs a start address and a byte length for each region, chooses a sample format and sets the run bit. Each sample-request strobe then yields one read request. The request carries the current absolute address and is held until the memory side acknowledges it.

On each acknowledge the engine advances by the byte size of one sample frame. When it steps past the end of the active region, three things happen in the same cycle: that region's finished flag is raised, the engine jumps to the start of the other region, and the offset restarts at zero. Pending finished flags drive an interrupt line. Software acknowledges a flag by writing a one back to its bit.

Both the absolute position and the offset within the active region can be read back. This lets a driver see exactly where playback stands.

Top module: `pingpong_dma_addr`

## Requirements
- R1: After reset the start, length, position, offset and control registers read zero, the format register reads 0x0010, the flag register reads zero and irq_o is low.
- R2: Register word indices are: 0 control, 1 flags, 2 start A, 3 start B, 4 length A, 5 length B, 6 position (read-only), 7 offset (read-only), 8 format, 9 global status (read-only). Any other index reads zero.
- R3: Control bit 0 is the run bit. While it is clear, sample_req_i is ignored: no request is raised and the position and offset hold. Setting it again resumes from the held position.
- R4: When the engine is running and idle, a sample_req_i pulse raises rd_req_o in the next cycle, with rd_addr_o equal to the current position. rd_req_o and rd_addr_o then hold until the cycle after rd_ack_i. Further sample_req_i pulses while a request is outstanding are ignored.
- R5: The step is 1 byte when format bits 5:4 are 00, 2 bytes when they are 01 or 10, and 4 bytes when they are 11. Bit 4 means 16-bit samples and bit 5 means stereo. After an acknowledge that does not end the region, the position and the offset each grow by the step.
- R6: An acknowledge for which offset plus step is at least the active region's length sets that region's finished flag. In the same cycle the position becomes the other region's start address and the offset becomes zero. Region A is played first.
- R7: A region of length zero yields exactly one request before the engine switches regions.
- R8: The flag register shows region A finished in bit 1 and region B finished in bit 2; all other bits read zero. Writing a one to a bit clears that flag, and writing all ones clears both. A flag set in the same cycle as its clear stays set.
- R9: irq_o and global status bit 0 are high exactly while at least one finished flag is pending.
- R10: Writing control with bit 1 set reloads the position to start A, the offset to zero and the active region to A, and drops any outstanding request. Bit 1 reads back as zero.
- R11: The format register keeps bits 5:0 as written; bits 3:0 hold the rate code and do not affect the step. Bits above 5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_idx_i (combinational) |
| sample_req_i | input | 1 | One-cycle request for the next sample |
| rd_req_o | output | 1 | Read request outstanding |
| rd_addr_o | output | 32 | Address of the outstanding read |
| rd_ack_i | input | 1 | Read acknowledge |
| irq_o | output | 1 | Any finished flag pending |

## Verification
Two cases are hard to reach from the ports. The first is a clear write to a flag landing in exactly the cycle that sets the same flag. The bench reaches it by driving the flag-register write together with the rd_ack_i that ends a region, on the same edge. The second is a region of zero length. It is reached by reprogramming a length to zero and rewinding, so that the very next acknowledge must switch regions. Random rounds vary the format, the start addresses, the lengths (zero included) and the acknowledge latency. They also fire extra sample strobes while a request is outstanding.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned STEP_W = 3;
  localparam int unsigned FMT_W  = 6;
  localparam logic [FMT_W-1:0] FMT_RESET = 6'h10;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL    = 4'd0,
    IDX_FLAGS   = 4'd1,
    IDX_START_A = 4'd2,
    IDX_START_B = 4'd3,
    IDX_LEN_A   = 4'd4,
    IDX_LEN_B   = 4'd5,
    IDX_POS     = 4'd6,
    IDX_OFS     = 4'd7,
    IDX_FMT     = 4'd8,
    IDX_GSTAT   = 4'd9
  } reg_idx_e;

  // bytes per sample frame from width and channel flags
  function automatic logic [STEP_W-1:0] step_bytes(input logic wide, input logic stereo);
    case ({wide, stereo})
      2'b00:   return STEP_W'(1);
      2'b11:   return STEP_W'(4);
      default: return STEP_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fin_a_i,
  input  logic              fin_b_i,
  input  logic [ADDR_W-1:0] pos_i,
  input  logic [LEN_W-1:0]  ofs_i,
  output logic              run_o,
  output logic              rewind_o,
  output logic [ADDR_W-1:0] start_a_o,
  output logic [ADDR_W-1:0] start_b_o,
  output logic [LEN_W-1:0]  len_a_o,
  output logic [LEN_W-1:0]  len_b_o,
  output logic [STEP_W-1:0] step_o,
  output logic              pend_o
);
  logic              run_q;
  logic [ADDR_W-1:0] start_a_q, start_b_q;
  logic [LEN_W-1:0]  len_a_q, len_b_q;
  logic [FMT_W-1:0]  fmt_q;
  logic [1:0]        flags_q;   // [0]=A, [1]=B
  logic [1:0]        clr;
  reg_idx_e          idx;

  assign idx = reg_idx_e'(idx_i);
  assign clr = (we_i && idx == IDX_FLAGS) ? {wdata_i[2], wdata_i[1]} : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      start_a_q <= '0;
      start_b_q <= '0;
      len_a_q   <= '0;
      len_b_q   <= '0;
      fmt_q     <= FMT_RESET;
    end else if (we_i) begin
      case (idx)
        IDX_CTRL:    run_q     <= wdata_i[0];
        IDX_START_A: start_a_q <= wdata_i[ADDR_W-1:0];
        IDX_START_B: start_b_q <= wdata_i[ADDR_W-1:0];
        IDX_LEN_A:   len_a_q   <= wdata_i[LEN_W-1:0];
        IDX_LEN_B:   len_b_q   <= wdata_i[LEN_W-1:0];
        IDX_FMT:     fmt_q     <= wdata_i[FMT_W-1:0];
        default: ;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= 2'b00;
    else         flags_q <= (flags_q & ~clr) | {fin_b_i, fin_a_i};
  end

  always_comb begin
    case (idx)
      IDX_CTRL:    rdata_o = DATA_W'(run_q);
      IDX_FLAGS:   rdata_o = DATA_W'({flags_q, 1'b0});
      IDX_START_A: rdata_o = DATA_W'(start_a_q);
      IDX_START_B: rdata_o = DATA_W'(start_b_q);
      IDX_LEN_A:   rdata_o = DATA_W'(len_a_q);
      IDX_LEN_B:   rdata_o = DATA_W'(len_b_q);
      IDX_POS:     rdata_o = DATA_W'(pos_i);
      IDX_OFS:     rdata_o = DATA_W'(ofs_i);
      IDX_FMT:     rdata_o = DATA_W'(fmt_q);
      IDX_GSTAT:   rdata_o = DATA_W'(|flags_q);
      default:     rdata_o = '0;
    endcase
  end

  assign run_o     = run_q;
  assign rewind_o  = we_i && idx == IDX_CTRL && wdata_i[1];
  assign start_a_o = start_a_q;
  assign start_b_o = start_b_q;
  assign len_a_o   = len_a_q;
  assign len_b_o   = len_b_q;
  assign step_o    = step_bytes(fmt_q[4], fmt_q[5]);
  assign pend_o    = |flags_q;

  a_r6_fin_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_a_i || fin_b_i) |=> pend_o);
  a_r8_flag_a_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !(we_i && idx_i == 4'd1 && wdata_i[1])) |=> flags_q[0]);
  a_r8_flag_b_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[1] && !(we_i && idx_i == 4'd1 && wdata_i[2])) |=> flags_q[1]);
endmodule

// File: rtl/pp_walker.sv
module pp_walker
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rewind_i,
  input  logic              sample_req_i,
  input  logic              rd_ack_i,
  input  logic [ADDR_W-1:0] start_a_i,
  input  logic [ADDR_W-1:0] start_b_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] pos_o,
  output logic [LEN_W-1:0]  ofs_o,
  output logic              fin_a_o,
  output logic              fin_b_o
);
  localparam int unsigned OFS_XW = LEN_W + 1;

  logic              busy_q, side_q;  // side_q: 0 = region A
  logic [ADDR_W-1:0] pos_q;
  logic [LEN_W-1:0]  ofs_q;
  logic [LEN_W-1:0]  cur_len;
  logic [OFS_XW-1:0] ofs_nx;
  logic              wrap, fire;

  assign cur_len = side_q ? len_b_i : len_a_i;
  assign ofs_nx  = OFS_XW'(ofs_q) + OFS_XW'(step_i);
  // zero length wraps on the first step
  assign wrap    = ofs_nx >= OFS_XW'(cur_len);
  assign fire    = busy_q && rd_ack_i && !rewind_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      side_q <= 1'b0;
      pos_q  <= '0;
      ofs_q  <= '0;
    end else if (rewind_i) begin
      busy_q <= 1'b0;
      side_q <= 1'b0;
      pos_q  <= start_a_i;
      ofs_q  <= '0;
    end else begin
      if (!busy_q && run_i && sample_req_i) busy_q <= 1'b1;
      if (fire) begin
        busy_q <= 1'b0;
        if (wrap) begin
          side_q <= ~side_q;
          pos_q  <= side_q ? start_a_i : start_b_i;
          ofs_q  <= '0;
        end else begin
          pos_q  <= pos_q + ADDR_W'(step_i);
          ofs_q  <= ofs_nx[LEN_W-1:0];
        end
      end
    end
  end

  assign rd_req_o  = busy_q;
  assign rd_addr_o = pos_q;
  assign pos_o     = pos_q;
  assign ofs_o     = ofs_q;
  assign fin_a_o   = fire && wrap && !side_q;
  assign fin_b_o   = fire && wrap && side_q;

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !rewind_i) |=> (rd_req_o && $stable(rd_addr_o)));
  a_r3_stopped_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !rd_req_o) |=> !rd_req_o);
  a_r6_wrap_zero_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_a_o || fin_b_o) |=> (ofs_o == '0 && !rd_req_o));
endmodule

// File: rtl/pingpong_dma_addr.sv
module pingpong_dma_addr
  import pp_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sample_req_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  output logic              irq_o
);
  logic              run, rewind, fin_a, fin_b;
  logic [ADDR_W-1:0] start_a, start_b, pos;
  logic [LEN_W-1:0]  len_a, len_b, ofs;
  logic [STEP_W-1:0] step;

  pp_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .fin_a_i(fin_a), .fin_b_i(fin_b), .pos_i(pos), .ofs_i(ofs),
    .run_o(run), .rewind_o(rewind),
    .start_a_o(start_a), .start_b_o(start_b), .len_a_o(len_a), .len_b_o(len_b),
    .step_o(step), .pend_o(irq_o)
  );

  pp_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk_i, .rst_ni,
    .run_i(run), .rewind_i(rewind), .sample_req_i, .rd_ack_i,
    .start_a_i(start_a), .start_b_i(start_b), .len_a_i(len_a), .len_b_i(len_b),
    .step_i(step), .rd_req_o, .rd_addr_o, .pos_o(pos), .ofs_o(ofs),
    .fin_a_o(fin_a), .fin_b_o(fin_b)
  );
endmodule

// File: tb/tb_pingpong_dma_addr.sv
`timescale 1ns/100ps
module tb_pingpong_dma_addr;
  localparam int I_CTRL = 0, I_FLAGS = 1, I_SA = 2, I_SB = 3, I_LA = 4, I_LB = 5,
                 I_POS = 6, I_OFS = 7, I_FMT = 8, I_GST = 9;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, sreq = 1'b0, ack = 1'b0;
  logic [3:0]  idx = '0;
  logic [31:0] wdata = '0, rdata, raddr;
  logic        rreq, irq;

  int n_chk = 0, n_err = 0;

  logic [31:0] m_start [2];
  int          m_len [2];
  logic [31:0] m_pos;
  int          m_ofs, m_side, m_step;
  logic [1:0]  m_flags;   // [0]=A [1]=B

  always #2.5 clk = ~clk;

  pingpong_dma_addr dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_idx_i(idx), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sample_req_i(sreq), .rd_req_o(rreq), .rd_addr_o(raddr),
    .rd_ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int step_of(input logic [31:0] fmt);
    case (fmt[5:4])
      2'b00: return 1;
      2'b11: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk); we = 1'b1; idx = 4'(i); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int i, output logic [31:0] d);
    idx = 4'(i); #1; d = rdata;
  endtask

  task automatic chk_reg(input string req, input int i, input logic [31:0] exp);
    logic [31:0] d;
    rd(i, d);
    chk(req, d, exp);
  endtask

  function automatic logic [31:0] flag_word();
    return {29'b0, m_flags, 1'b0};
  endfunction

  task automatic rewind_run();
    wr(I_CTRL, 32'h3);
    m_pos = m_start[0]; m_ofs = 0; m_side = 0;
  endtask

  // one request/ack cycle; clr_same drives a flag clear on the ack edge
  task automatic do_sample(input int delay, input logic [1:0] clr_same);
    int nx;
    @(negedge clk); sreq = 1'b1;
    @(negedge clk); sreq = 1'b0;
    chk("R4 req raised", 32'(rreq), 32'd1);
    chk("R4 addr", raddr, m_pos);
    for (int k = 0; k < delay; k++) begin
      sreq = 1'b1;  // ignored while outstanding
      @(negedge clk);
      chk("R4 req held", 32'(rreq), 32'd1);
      chk("R4 addr held", raddr, m_pos);
    end
    sreq = 1'b0; ack = 1'b1;
    if (clr_same != 2'b00) begin
      we = 1'b1; idx = 4'(I_FLAGS); wdata = {29'b0, clr_same, 1'b0};
    end
    @(negedge clk); ack = 1'b0; we = 1'b0;
    m_flags &= ~clr_same;
    nx = m_ofs + m_step;
    if (nx >= m_len[m_side]) begin
      m_flags[m_side] = 1'b1;
      m_side ^= 1;
      m_pos = m_start[m_side];
      m_ofs = 0;
    end else begin
      m_pos += 32'(m_step);
      m_ofs = nx;
    end
    chk("R4 req dropped", 32'(rreq), 32'd0);
    chk_reg("R5/R6 pos", I_POS, m_pos);
    chk_reg("R5/R6 ofs", I_OFS, 32'(m_ofs));
    chk_reg("R8 flags", I_FLAGS, flag_word());
    chk("R9 irq", 32'(irq), 32'(|m_flags));
  endtask

  task automatic prog(input logic [31:0] sa, input int la, input logic [31:0] sb, input int lb,
                      input logic [31:0] fmt);
    wr(I_SA, sa); wr(I_SB, sb); wr(I_LA, 32'(la)); wr(I_LB, 32'(lb)); wr(I_FMT, fmt);
    m_start[0] = sa; m_start[1] = sb; m_len[0] = la; m_len[1] = lb;
    m_step = step_of(fmt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset values
    for (int i = 0; i < 16; i++) begin
      rd(i, d);
      chk("R1/R2 reset read", d, (i == I_FMT) ? 32'h10 : 32'h0);
    end
    chk("R1 irq low", 32'(irq), 32'd0);

    prog(32'h0000_1000, 8, 32'h8000_0000, 6, 32'h10);
    chk_reg("R11 fmt readback", I_FMT, 32'h10);
    wr(I_FMT, 32'hFFFF_FF10);
    chk_reg("R11 fmt upper zero", I_FMT, 32'h10);

    // R3 stopped: strobe ignored
    @(negedge clk); sreq = 1'b1; @(negedge clk); sreq = 1'b0;
    chk("R3 no req when stopped", 32'(rreq), 32'd0);
    chk_reg("R3 pos held", I_POS, 32'h0);

    rewind_run();
    chk_reg("R10 rewind pos", I_POS, 32'h1000);
    chk_reg("R10 ctrl bit1 reads 0", I_CTRL, 32'h1);

    // region A then B, step 2
    for (int i = 0; i < 4; i++) do_sample(i, 2'b00);
    chk_reg("R6 flag A", I_FLAGS, 32'h2);
    chk_reg("R9 gstat", I_GST, 32'h1);
    for (int i = 0; i < 3; i++) do_sample(1, 2'b00);
    chk_reg("R8 both flags", I_FLAGS, 32'h6);
    wr(I_FLAGS, 32'h2); m_flags[0] = 1'b0;
    chk_reg("R8 clear A only", I_FLAGS, 32'h4);
    wr(I_FLAGS, 32'hFFFF_FFFF); m_flags = '0;
    chk_reg("R8 clear all", I_FLAGS, 32'h0);
    chk_reg("R9 gstat clear", I_GST, 32'h0);
    chk("R9 irq clear", 32'(irq), 32'd0);

    // R3 pause mid-region and resume
    do_sample(0, 2'b00);
    wr(I_CTRL, 32'h0);
    @(negedge clk); sreq = 1'b1; @(negedge clk); sreq = 1'b0;
    chk("R3 paused no req", 32'(rreq), 32'd0);
    chk_reg("R3 paused pos", I_POS, m_pos);
    chk_reg("R3 paused ofs", I_OFS, 32'(m_ofs));
    wr(I_CTRL, 32'h1);
    do_sample(0, 2'b00);

    // R8 set wins over clear: end region with clear on same edge
    rewind_run();
    for (int i = 0; i < 3; i++) do_sample(0, 2'b00);
    wr(I_FLAGS, 32'h6); m_flags = '0;
    do_sample(0, 2'b01);
    chk_reg("R8 set beats clear", I_FLAGS, 32'h2);
    wr(I_FLAGS, 32'hFFFF_FFFF); m_flags = '0;

    // R7 zero length, R5 byte step
    prog(32'h0000_2000, 0, 32'h0000_3000, 3, 32'h0);
    rewind_run();
    do_sample(0, 2'b00);
    chk_reg("R7 zero length switched", I_POS, 32'h3000);
    for (int i = 0; i < 3; i++) do_sample(0, 2'b00);
    chk_reg("R7 back to A", I_POS, 32'h2000);
    wr(I_FLAGS, 32'hFFFF_FFFF); m_flags = '0;

    // R10 rewind drops outstanding request
    @(negedge clk); sreq = 1'b1; @(negedge clk); sreq = 1'b0;
    rewind_run();
    chk("R10 req dropped", 32'(rreq), 32'd0);
    chk_reg("R10 ofs", I_OFS, 32'h0);

    // random rounds
    for (int r = 0; r < 12; r++) begin
      logic [31:0] fmt;
      fmt = {26'b0, 6'($urandom)};
      prog({$urandom} & 32'hFFFF_FFF0, int'($urandom_range(0, 20)),
           {$urandom} & 32'hFFFF_FFF0, int'($urandom_range(0, 20)), fmt);
      chk_reg("R11 fmt random", I_FMT, fmt);
      rewind_run();
      for (int s = 0; s < 30; s++) begin
        do_sample(int'($urandom_range(0, 3)), 2'b00);
        if ($urandom_range(0, 7) == 0) begin
          logic [1:0] c;
          c = 2'($urandom);
          wr(I_FLAGS, {29'b0, c, 1'b0});
          m_flags &= ~c;
          chk_reg("R8 random clear", I_FLAGS, flag_word());
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule